// File: doc/BRIEF.md
# Shared-Timer Full-Duplex Serial Port

This block is an 8N1 asynchronous serial port that sends and receives at the same time while using a single free-running counter for both directions. No direction owns a baud-rate divider. Each direction keeps its own compare register on the shared counter. When the counter reaches that compare value, the direction takes its next action. It then moves the compare value forward by one bit period, using arithmetic modulo the counter width.

The transmitter never writes its line in a direct way. For each bit it arms a drive-high or drive-low action, and that action is applied when the transmit compare value matches. The receiver waits for a falling edge on the synchronised input. It then places its first sample one and a half bit periods later and takes one sample per bit period after that. Completed bytes enter a two-entry queue that the host drains with a read strobe. A byte that arrives while the queue is full sets a sticky overrun flag. A bad stop bit sets a sticky framing flag. The bit period is a count of clock cycles presented on an input, for example 139 for 57600 baud or 833 for 9600 baud at 8 MHz.

Top module: `shared_timer_uart`

## Requirements
- R1: After reset, `txd` is high, `tx_ready` is 1, `rx_avail` is 0, and both `err_overrun` and `err_frame` are 0.
- R2: The transmitter sends each accepted byte as one low start bit, then eight data bits LSB first, then one high stop bit. Each bit lasts `bit_period` cycles, and `txd` changes only on a transmit compare match.
- R3: `tx_ready` drops in the cycle after a byte is accepted. It returns only after the stop-bit edge has been applied. If a byte is accepted during that stop bit, its start edge comes exactly 10 bit periods after the previous start edge.
- R4: The receiver decodes an 8N1 frame on `rxd`, LSB first. The first data sample is taken 1.5 bit periods after the start edge is detected, and each later sample follows one bit period after the one before.
- R5: Transmission and reception run at the same time without disturbing each other.
- R6: Received bytes are queued in order, two entries deep. `rx_avail` is 1 while the queue holds data, and `rx_byte` shows the oldest entry. A `rx_take` pulse removes one entry, and a `rx_take` pulse on an empty queue has no effect.
- R7: A correctly framed byte that completes while the queue holds two entries is dropped, and `err_overrun` becomes 1 and stays 1. The two stored bytes remain unchanged.
- R8: A frame whose stop-bit sample is low is discarded. It sets `err_frame`, which stays 1, and it does not stop the receiver from taking the next good frame.
- R9: Transmit and receive schedules that cross the counter wrap point produce correct frames.
- R10: Bit periods from 16 to 833 cycles work. This range includes 139 (57600 baud) and 833 (9600 baud) at 8 MHz.
- R11: While a frame is being received, falling edges inside the data bits do not restart reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_period | input | CNT_W | Length of one bit in clock cycles |
| tx_byte | input | DATA_W | Byte offered for sending |
| tx_valid | input | 1 | `tx_byte` is valid |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_byte | output | DATA_W | Oldest received byte |
| rx_avail | output | 1 | Receive queue is not empty |
| rx_take | input | 1 | Remove the oldest received byte |
| err_overrun | output | 1 | Sticky: a byte was lost because the queue was full |
| err_frame | output | 1 | Sticky: a stop bit was sampled low |

## Verification
A transmit compare value that has drifted shows up on `txd` as a bit that is longer or shorter than it should be. An independent decoder that samples at mid-bit then misreads a byte within one frame, and the spacing between back-to-back start edges is no longer exactly ten periods. A receive compare or bit index that has gone wrong produces a wrong byte on `rx_byte`, or no byte at all, by the end of the frame in question. This is checked in loopback and against a separate serial driver running at the same time. Queue pointer faults show up as reordered or repeated bytes on the next reads, and they also show up in the state of `rx_avail` after an overrun or an empty read. Wrap faults appear only in the frames that cross the counter limit, so one run of traffic straddles it in both directions.

// File: rtl/uart_pkg.sv
// Shared types for the shared-timer serial port.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_BUSY, TX_TAIL} tx_state_t;
    typedef enum logic       {RX_IDLE, RX_RECV} rx_state_t;
    localparam int STOP_BITS  = 1;
    localparam int START_BITS = 1;
endpackage

// File: rtl/uart_timebase.sv
// Free-running counter shared by both directions.
// Assumes: wraps modulo 2**CNT_W; users compare with modular arithmetic.
module uart_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    // advance the shared time by one every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/uart_tx_chan.sv
// Transmit channel: arms a set or clear action per bit and applies it when
// the compare value equals the shared counter, then advances the compare.
// Assumes: bit_period >= 2 and stable while a frame is in flight.
module uart_tx_chan
    import uart_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  period,
    input  logic [DATA_W-1:0] data,
    input  logic              valid,
    output logic              ready,
    output logic              line
);
    localparam int FRM   = DATA_W + START_BITS + STOP_BITS;
    localparam int IDX_W = $clog2(FRM);

    tx_state_t        state;
    logic [CNT_W-1:0] cmp;
    logic [FRM-1:0]   frame;
    logic [IDX_W-1:0] idx;
    logic             hit, accept, act_hi;

    assign ready  = (state != TX_BUSY);
    assign accept = valid && ready;
    assign hit    = (state != TX_IDLE) && (cnt == cmp);
    assign act_hi = frame[0];   // armed action: 1 = set, 0 = clear

    // schedule and apply one bit edge per compare match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cmp   <= '0;
            frame <= '1;
            idx   <= '0;
            line  <= 1'b1;
        end else begin
            case (state)
                TX_IDLE: if (accept) begin
                    frame <= {1'b1, data, 1'b0};
                    idx   <= '0;
                    cmp   <= cnt + CNT_W'(1);
                    state <= TX_BUSY;
                end
                TX_BUSY: if (hit) begin
                    line  <= act_hi;
                    frame <= {1'b1, frame[FRM-1:1]};
                    cmp   <= cmp + period;
                    if (idx == IDX_W'(FRM-1)) state <= TX_TAIL;
                    else                      idx   <= idx + IDX_W'(1);
                end
                TX_TAIL: begin
                    if (accept) begin
                        frame <= {1'b1, data, 1'b0};
                        idx   <= '0;
                        state <= TX_BUSY;
                        if (hit) cmp <= cmp + CNT_W'(1);
                    end else if (hit) begin
                        state <= TX_IDLE;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    p_line_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == TX_BUSY && cnt == cmp) |=> $stable(line));
    p_accept_drops_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> !ready);
endmodule

// File: rtl/uart_rx_chan.sv
// Receive channel: a falling edge on the synchronised input arms a compare
// 1.5 periods ahead; each match samples one bit and advances the compare.
// Assumes: bit_period >= 16; edge detection is masked while receiving.
module uart_rx_chan
    import uart_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  period,
    input  logic              pin,
    input  logic              q_full,
    output logic              push,
    output logic [DATA_W-1:0] byte_out,
    output logic              overrun,
    output logic              frame_err
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  cmp;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              s1, s2, prev, fall, hit, stop_hit;

    assign fall     = prev && !s2;
    assign hit      = (state == RX_RECV) && (cnt == cmp);
    assign stop_hit = hit && (idx == IDX_W'(DATA_W));
    assign push     = stop_hit && s2 && !q_full;
    assign byte_out = shreg;

    // bring the asynchronous pin into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) {s1, s2, prev} <= 3'b111;
        else        {s1, s2, prev} <= {pin, s1, s2};
    end

    // edge-armed sampling driven by the receive compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cmp   <= '0;
            idx   <= '0;
            shreg <= '0;
        end else if (state == RX_IDLE) begin
            if (fall) begin
                cmp   <= cnt + period + (period >> 1);
                idx   <= '0;
                state <= RX_RECV;
            end
        end else if (hit) begin
            cmp <= cmp + period;
            if (idx == IDX_W'(DATA_W)) begin
                state <= RX_IDLE;
            end else begin
                shreg <= {s2, shreg[DATA_W-1:1]};
                idx   <= idx + IDX_W'(1);
            end
        end
    end

    // sticky error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            if (stop_hit && s2 && q_full) overrun   <= 1'b1;
            if (stop_hit && !s2)          frame_err <= 1'b1;
        end
    end

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    p_frame_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
    p_masked_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_RECV && !hit) |=> state == RX_RECV);
endmodule

// File: rtl/uart_rx_fifo.sv
// Small in-order byte queue for received data.
// Assumes: writer never pushes when full (gated outside).
module uart_rx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              not_empty,
    output logic              full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic [CW-1:0]     count;
    logic              do_pop, do_push;

    assign not_empty = (count != '0);
    assign full      = (count == CW'(DEPTH));
    assign rdata     = mem[rp];
    assign do_pop    = pop && not_empty;
    assign do_push   = push && !full;

    // write side storage
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !not_empty && !push) |=> !not_empty);
endmodule

// File: rtl/shared_timer_uart.sv
// Full-duplex 8N1 serial port whose two directions share one free-running
// counter; each direction schedules itself with its own compare value.
// Assumes: bit_period in [16, 2**CNT_W/2), changed only while idle.
module shared_timer_uart #(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  bit_period,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_avail,
    input  logic              rx_take,
    output logic              err_overrun,
    output logic              err_frame
);
    logic [CNT_W-1:0]  now;
    logic              q_push, q_full;
    logic [DATA_W-1:0] q_wdata;

    uart_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .cnt(now));

    uart_tx_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cnt(now), .period(bit_period),
        .data(tx_byte), .valid(tx_valid), .ready(tx_ready), .line(txd));

    uart_rx_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cnt(now), .period(bit_period),
        .pin(rxd), .q_full(q_full), .push(q_push), .byte_out(q_wdata),
        .overrun(err_overrun), .frame_err(err_frame));

    uart_rx_fifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push(q_push), .wdata(q_wdata),
        .pop(rx_take), .rdata(rx_byte), .not_empty(rx_avail), .full(q_full));
endmodule

// File: tb/tb_shared_timer_uart.sv
module tb_shared_timer_uart;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int          per = 139;
    logic [CW-1:0] bp;
    logic [7:0]  tx_byte = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready, txd;
    logic        mdl_line = 1'b1, loop = 1'b0;
    logic        rxd;
    logic [7:0]  rx_byte;
    logic        rx_avail, rx_take, err_overrun, err_frame;
    logic        mon_pop = 1'b0, force_pop = 1'b0;
    bit          auto_read = 1'b1;

    assign bp      = per[CW-1:0];
    assign rxd     = loop ? txd : mdl_line;
    assign rx_take = mon_pop | force_pop;

    shared_timer_uart #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .bit_period(bp), .tx_byte(tx_byte),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
        .rx_byte(rx_byte), .rx_avail(rx_avail), .rx_take(rx_take),
        .err_overrun(err_overrun), .err_frame(err_frame));

    int total = 0, bad = 0, cyc = 0, gap10 = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: independent mid-bit decoder on txd
    always begin
        int t0;
        logic [7:0] b;
        int last_start;
        @(negedge txd);
        @(negedge clk);
        t0 = cyc;
        repeat (per/2 - 1) @(negedge clk);
        chk(txd == 1'b0, "R2 start bit low", txd, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (per) @(negedge clk);
            b[i] = txd;
        end
        repeat (per) @(negedge clk);
        chk(txd == 1'b1, "R2 stop bit high", txd, 1);
        if (exp_tx.size() == 0) chk(0, "R2 unexpected tx byte", b, -1);
        else begin
            logic [7:0] e;
            e = exp_tx.pop_front();
            chk(b == e, "R2 tx byte", b, e);
        end
        last_start = last_start_g;
        if (t0 - last_start == 10*per) gap10++;
        last_start_g = t0;
    end
    int last_start_g = -100000;

    // monitor: read the receive queue and compare in order
    always @(negedge clk) begin
        mon_pop = 1'b0;
        if (rst_n && auto_read && rx_avail) begin
            if (exp_rx.size() == 0) chk(0, "R4 unexpected rx byte", rx_byte, -1);
            else begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                chk(rx_byte == e, "R4 R6 rx byte", rx_byte, e);
            end
            mon_pop = 1'b1;
        end
    end

    task automatic send_tx(input logic [7:0] b, input bit lp);
        exp_tx.push_back(b);
        if (lp) exp_rx.push_back(b);
        @(negedge clk);
        tx_byte  = b;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R3 ready low after accept", tx_ready, 0);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        @(negedge clk);
        mdl_line = 1'b0;
        repeat (per) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            mdl_line = b[i];
            repeat (per) @(negedge clk);
        end
        mdl_line = stop;
        repeat (per) @(negedge clk);
        mdl_line = 1'b1;
    endtask

    task automatic tx_stream(input int n, input int seed, input bit lp);
        int g0;
        g0 = gap10;
        for (int i = 0; i < n; i++) send_tx(8'((seed*37 + i*91) ^ (i*8'h55)), lp);
        wait (exp_tx.size() == 0);
        repeat (2) @(negedge clk);
        chk(gap10 - g0 == n - 1, "R3 back-to-back spacing 10 periods", gap10 - g0, n - 1);
    endtask

    task automatic rx_stream(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'((seed*53 + i*29) ^ 8'hA5);
            exp_rx.push_back(b);
            send_rx(b, 1'b1);
        end
    endtask

    task automatic drain();
        while (exp_tx.size() != 0 || exp_rx.size() != 0) @(negedge clk);
        repeat (2*per) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 190000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd idle", txd, 1);
        chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
        chk(rx_avail == 1'b0, "R1 rx_avail", rx_avail, 0);
        chk(err_overrun == 1'b0 && err_frame == 1'b0, "R1 flags", {err_overrun, err_frame}, 0);

        // R5 R10 full duplex at 57600 baud-equivalent
        per = 139;
        fork tx_stream(5, 1, 0); rx_stream(5, 2); join
        drain();
        // R4 R11 loopback, data with inner falling edges
        loop = 1'b1;
        tx_stream(4, 3, 1);
        drain();
        // R10 shortest period in loopback
        per = 16;
        tx_stream(6, 4, 1);
        drain();
        loop = 1'b0;
        // R10 9600 baud-equivalent, duplex
        per = 833;
        fork tx_stream(2, 5, 0); rx_stream(2, 6); join
        drain();

        // R6 take on empty queue has no effect
        per = 40;
        @(negedge clk); force_pop = 1'b1; @(negedge clk); force_pop = 1'b0;
        chk(rx_avail == 1'b0, "R6 empty take", rx_avail, 0);
        rx_stream(1, 7);
        drain();
        chk(err_overrun == 1'b0, "R7 no overrun yet", err_overrun, 0);

        // R7 overrun: third byte dropped, first two kept in order
        auto_read = 0;
        exp_rx.push_back(8'h3C);
        exp_rx.push_back(8'hC3);
        send_rx(8'h3C, 1'b1);
        send_rx(8'hC3, 1'b1);
        send_rx(8'h7E, 1'b1);
        repeat (2*per) @(negedge clk);
        chk(err_overrun == 1'b1, "R7 overrun set", err_overrun, 1);
        chk(rx_byte == 8'h3C, "R7 oldest kept", rx_byte, 8'h3C);
        chk(err_frame == 1'b0, "R8 no frame error yet", err_frame, 0);
        auto_read = 1;
        drain();
        chk(rx_avail == 1'b0, "R7 dropped byte absent", rx_avail, 0);
        chk(err_overrun == 1'b1, "R7 overrun sticky", err_overrun, 1);

        // R8 bad stop bit discards the frame, next good one received
        send_rx(8'hA5, 1'b0);
        repeat (2*per) @(negedge clk);
        chk(err_frame == 1'b1, "R8 frame error set", err_frame, 1);
        chk(rx_avail == 1'b0, "R8 bad frame discarded", rx_avail, 0);
        rx_stream(1, 9);
        drain();

        // R9 traffic across counter wrap
        per = 139;
        while (cyc < 65536 - 2500) @(negedge clk);
        begin
            int c0;
            c0 = cyc;
            fork tx_stream(4, 10, 0); rx_stream(4, 11); join
            drain();
            chk(c0 < 65536 && cyc > 65536 + 2000, "R9 stream crossed wrap", cyc, 65536);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule